// File: doc/BRIEF.md
# Dead-Zone Gate and Lock Monitor

This block sits beside a counter-based phase and frequency detector. It looks at the latched phase code from that detector and decides when the fast analog mixer path may act. The analog path is allowed only while the latched code sits exactly on the zero-phase code, the dead zone. In that state it forwards a digital quadrature copy of the reference clock to the mixer. Outside the dead zone it holds that drive inactive. When the code moves away from the dead zone, the analog path is cut off and the digital detector carries the loop alone.

The block also reports lock and saturation status for data validation. A registered in-lock bit follows the code, and only at latch strobes. Upper and lower saturation are passed out as separate registered status bits. Two sticky flags record history and stay set until software-independent clear logic pulses a clear input. The first records any loss of phase memory, meaning a saturation. The second, which a parameter can remove, records any departure from the dead zone, meaning a cycle slip. The analog-path enable input selects the operating mode. With the enable high the two detectors work together; with it low the loop runs on the digital detector only. Analog-only operation comes from disabling the digital detector upstream, and this block still passes the gated drive in that case.

Top module: `dz_lock_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is 0.
- R2: On a clock edge where the latch strobe is high, the in-lock output takes the value (code == ZERO_CODE) and shows it from the next cycle. ZERO_CODE is MSB=1, LSB=1 and all other bits 0 (8'h81 at the default width). On edges without a strobe the in-lock output keeps its value, even if the code changes.
- R3: The gated quadrature output is a register. After each edge it equals the quadrature input AND the analog enable AND the in-lock value that held before that edge.
- R4: While the analog enable is low, the gated quadrature output is 0 after every edge, whatever the lock state and the quadrature input.
- R5: The upper and lower saturation outputs are the corresponding inputs delayed by one clock.
- R6: The sticky saturation flag sets on an edge where either saturation input is high. It then stays set until a clear.
- R7: The sticky slip flag sets on an edge where the strobe is high, the in-lock output is 1, and the code differs from ZERO_CODE. It then stays set until a clear.
- R8: When a flag's set condition and the clear input are high on the same edge, the flag ends up set.
- R9: A clear on an edge with no set condition drops the flag to 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_i | input | CODE_W | Latched phase code from the counter detector |
| latch_stb_i | input | 1 | High for one cycle when a new code is latched |
| lo_quad_i | input | 1 | Digital quadrature copy of the reference |
| analog_en_i | input | 1 | Enables the analog path |
| sat_hi_i | input | 1 | Upper saturation indication |
| sat_lo_i | input | 1 | Lower saturation indication |
| flag_clr_i | input | 1 | Clears both sticky flags |
| lo_gated_o | output | 1 | Gated quadrature drive to the mixer |
| in_lock_o | output | 1 | Code equals the dead-zone code |
| sat_hi_o | output | 1 | Registered upper saturation |
| sat_lo_o | output | 1 | Registered lower saturation |
| sat_sticky_o | output | 1 | Saturation seen since the last clear |
| slip_sticky_o | output | 1 | Cycle slip seen since the last clear |

## Verification
Two functions can fall on the same edge: a flag's set event and the clear. The bench provokes this by pulsing the clear together with a saturation input, and together with a strobe that carries a non-zero code while locked. It judges the case by checking that each flag reads 1 in the following cycle. A second pairing has a strobe that drops lock on the same edge that the quadrature input is high. In that case the gated output must still pass the drive for that one cycle, because it uses the lock value from before the edge.

// File: rtl/dz_pkg.sv
package dz_pkg;
   localparam int MIN_CODE_W = 3;

   typedef struct packed {
      logic hi;
      logic lo;
   } sat_pair_t;
endpackage

// File: rtl/dz_lock_detect.sv
module dz_lock_detect #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   input  logic              stb_i,
   output logic              at_zero_o,
   output logic              in_lock_o
);
   localparam logic [CODE_W-1:0] ZERO_CODE = {1'b1, {(CODE_W-2){1'b0}}, 1'b1};

   logic lock_q;

   assign at_zero_o = (code_i == ZERO_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n)     lock_q <= 1'b0;
      else if (stb_i) lock_q <= at_zero_o;
   end

   assign in_lock_o = lock_q;

   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_i |=> $stable(lock_q)); // R2
   AST_LOCK_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      stb_i |=> (lock_q == $past(code_i == ZERO_CODE))); // R2
endmodule

// File: rtl/dz_lo_gate.sv
module dz_lo_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic lo_i,
   input  logic en_i,
   input  logic lock_i,
   output logic lo_o
);
   logic lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lo_q <= 1'b0;
      else        lo_q <= lo_i & en_i & lock_i;
   end

   assign lo_o = lo_q;

   AST_GATE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_i |=> !lo_q); // R3
   AST_GATE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !lo_q); // R4
endmodule

// File: rtl/dz_sticky_flag.sv
module dz_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q); // R8
   AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q); // R6
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_q); // R9
endmodule

// File: rtl/dz_lock_gate.sv
module dz_lock_gate #(
   parameter int CODE_W  = 8,
   parameter bit SLIP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   input  logic              latch_stb_i,
   input  logic              lo_quad_i,
   input  logic              analog_en_i,
   input  logic              sat_hi_i,
   input  logic              sat_lo_i,
   input  logic              flag_clr_i,
   output logic              lo_gated_o,
   output logic              in_lock_o,
   output logic              sat_hi_o,
   output logic              sat_lo_o,
   output logic              sat_sticky_o,
   output logic              slip_sticky_o
);
   import dz_pkg::*;

   initial begin
      if (CODE_W < MIN_CODE_W)
         $error("dz_lock_gate: CODE_W must be at least %0d", MIN_CODE_W);
   end

   logic      at_zero;
   logic      lock;
   sat_pair_t sat_q;

   dz_lock_detect #(.CODE_W(CODE_W)) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .code_i    (code_i),
      .stb_i     (latch_stb_i),
      .at_zero_o (at_zero),
      .in_lock_o (lock)
   );

   dz_lo_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .lo_i   (lo_quad_i),
      .en_i   (analog_en_i),
      .lock_i (lock),
      .lo_o   (lo_gated_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) sat_q <= '0;
      else        sat_q <= '{hi: sat_hi_i, lo: sat_lo_i};
   end

   dz_sticky_flag u_sat_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (sat_hi_i | sat_lo_i),
      .clr_i  (flag_clr_i),
      .flag_o (sat_sticky_o)
   );

   generate
      if (SLIP_EN) begin : g_slip
         dz_sticky_flag u_slip_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (latch_stb_i & lock & ~at_zero),
            .clr_i  (flag_clr_i),
            .flag_o (slip_sticky_o)
         );
      end else begin : g_no_slip
         assign slip_sticky_o = 1'b0;
      end
   endgenerate

   assign in_lock_o = lock;
   assign sat_hi_o  = sat_q.hi;
   assign sat_lo_o  = sat_q.lo;

   AST_SAT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sat_hi_o == $past(sat_hi_i)) && (sat_lo_o == $past(sat_lo_i))); // R5
   AST_SAT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_hi_i || sat_lo_i) |=> sat_sticky_o); // R6
endmodule

// File: tb/sim_dz_lock_gate.sv
module sim_dz_lock_gate;
   localparam int  CODE_W = 8;
   localparam time PERIOD = 10;
   localparam logic [CODE_W-1:0] ZC = 8'h81;

   typedef struct {
      logic gated, lock, shi, slo, ssat, sslip;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [CODE_W-1:0] code = '0;
   logic stb = 0, lo = 0, en = 0, shi = 0, slo = 0, clr = 0;
   logic gated_o, lock_o, shi_o, slo_o, ssat_o, sslip_o;

   int checks = 0, failures = 0;
   bit done = 0;
   exp_t q[$];
   exp_t m = '{0, 0, 0, 0, 0, 0};

   always #(PERIOD/2) clk = ~clk;

   dz_lock_gate #(.CODE_W(CODE_W), .SLIP_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .code_i(code), .latch_stb_i(stb),
      .lo_quad_i(lo), .analog_en_i(en), .sat_hi_i(shi), .sat_lo_i(slo),
      .flag_clr_i(clr), .lo_gated_o(gated_o), .in_lock_o(lock_o),
      .sat_hi_o(shi_o), .sat_lo_o(slo_o), .sat_sticky_o(ssat_o),
      .slip_sticky_o(sslip_o));

   task automatic chk(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // driver: apply one cycle of stimulus and push the expected outputs after the edge
   task automatic step(logic [CODE_W-1:0] c, logic s, logic l, logic e,
                       logic h, logic w, logic k);
      exp_t n;
      @(negedge clk);
      code = c; stb = s; lo = l; en = e; shi = h; slo = w; clr = k;
      n.gated = l & e & m.lock;
      n.lock  = s ? (c == ZC) : m.lock;
      n.shi   = h;
      n.slo   = w;
      n.ssat  = (h | w) ? 1'b1 : (k ? 1'b0 : m.ssat);
      n.sslip = (s && m.lock && c != ZC) ? 1'b1 : (k ? 1'b0 : m.sslip);
      m = n;
      q.push_back(n);
   endtask

   // monitor
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(en ? "R3" : "R3 R4", gated_o, e.gated);
         chk("R2", lock_o, e.lock);
         chk("R5 hi", shi_o, e.shi);
         chk("R5 lo", slo_o, e.slo);
         chk("R6 R8 R9 sat", ssat_o, e.ssat);
         chk("R7 R8 R9 slip", sslip_o, e.sslip);
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk("R1 gated", gated_o, 0); chk("R1 lock", lock_o, 0);
      chk("R1 sat", ssat_o, 0);    chk("R1 slip", sslip_o, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 gated", gated_o, 0); chk("R1 lock", lock_o, 0);
      chk("R1 shi", shi_o, 0);     chk("R1 slo", slo_o, 0);
      chk("R1 sat", ssat_o, 0);    chk("R1 slip", sslip_o, 0);
      // not locked: quadrature blocked (R3)
      step(8'h10, 1, 1, 1, 0, 0, 0);
      // a code change without a strobe does not lock (R2)
      step(ZC, 0, 1, 1, 0, 0, 0);
      // lock on a strobe at the dead-zone code
      step(ZC, 1, 0, 1, 0, 0, 0);
      for (int i = 0; i < 6; i++) step(8'h22, 0, i[0], 1, 0, 0, 0); // R2 hold, R3 pass
      // digital-only mode (R4)
      for (int i = 0; i < 4; i++) step(ZC, 0, i[0], 0, 0, 0, 0);
      // saturation pulses (R5, R6)
      step(ZC, 0, 1, 1, 1, 0, 0);
      step(ZC, 0, 0, 1, 0, 0, 0);
      step(ZC, 0, 1, 1, 0, 1, 0);
      step(ZC, 0, 1, 1, 0, 0, 0);
      // clear alone (R9)
      step(ZC, 0, 1, 1, 0, 0, 1);
      step(ZC, 0, 0, 1, 0, 0, 0);
      // saturation and clear on the same edge (R8)
      step(ZC, 0, 0, 1, 0, 1, 1);
      step(ZC, 0, 0, 1, 0, 0, 0);
      // slip with quadrature high: gated still passes for that edge (R7, R3)
      step(8'h80, 1, 1, 1, 0, 0, 0);
      step(8'h80, 0, 1, 1, 0, 0, 0);
      // strobe with a non-zero code while unlocked: no new slip after clear (R7)
      step(8'h80, 0, 0, 1, 0, 0, 1);
      step(8'h7f, 1, 0, 1, 0, 0, 0);
      // relock, then slip and clear on the same edge (R8)
      step(ZC, 1, 0, 1, 0, 0, 0);
      step(8'hff, 1, 1, 1, 0, 0, 1);
      step(8'hff, 0, 0, 1, 0, 0, 0);
      // clear both (R9)
      step(8'hff, 0, 0, 1, 0, 0, 1);
      step(8'hff, 0, 0, 1, 0, 0, 0);
      step(8'hff, 0, 0, 1, 0, 0, 0);
      @(posedge clk); #2;
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            #(PERIOD*20000);
            if (!done) begin
               failures++;
               checks++;
               $display("FAIL watchdog actual=hung expected=finished");
            end
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule